// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A synthesizable model of a 16-bit static memory with active-low chip enable, write enable, output enable and two active-low byte-lane selects. The control inputs decide, every cycle, whether the memory is in standby, reads, writes or sits active with its bus idle. The lane selects decide which half of the word is stored or driven. A power-state output reports standby versus active.

The address is split into a 4-bit word-within-page field (low bits) and a page field (the remaining upper bits). The full organisation uses 17 address bits, which gives 8K pages of 16 words. Simulation builds can shrink the depth through the address-width parameter. Writes are stored on the rising edge of `clk` while write mode holds. Read data follows the address combinationally.

A parameter selects the data path. One variant uses separate `din`, `dout` and per-lane `dout_en` signals, which suits synthesis. The other variant also drives the shared bidirectional `dq` bus lane by lane and takes write data from it.

Top module: `sram16_lane_model`

## Requirements
- R1: The memory holds 2^ADDR_W words of 16 bits. `addr[3:0]` selects the word within a page and `addr[ADDR_W-1:4]` selects the page. Every address keeps its own contents.
- R2: While `ce_n`=1 the block is in standby: `dout_en`=00 and `power`=0. Nothing is written, whatever the other inputs are.
- R3: While `ce_n`=0 with `ub_n`=1 and `lb_n`=1 the block is also in standby: `dout_en`=00 and `power`=0. Nothing is written, even when `we_n`=0.
- R4: Write mode is `ce_n`=0, `we_n`=0 and at least one lane select low. At the rising `clk` edge, each selected lane of `din` is stored at `addr`. `dout_en` stays 00 during the write.
- R5: During write mode, `oe_n` has no effect. Writes store, and the bus stays undriven, for either level of `oe_n`.
- R6: Read mode is `ce_n`=0, `we_n`=1, `oe_n`=0 and at least one lane select low. In the same cycle, `dout` presents the stored word at `addr` and `dout_en` enables the selected lanes.
- R7: `lb_n` governs bits 7:0 (`dout_en[0]`) and `ub_n` governs bits 15:8 (`dout_en[1]`). An unselected lane is neither written nor driven, and its stored byte is preserved.
- R8: With `ce_n`=0, `we_n`=1, `oe_n`=1 and at least one lane select low, the bus is idle (`dout_en`=00) while `power`=1.
- R9: `power` is 1 in read, write and idle modes, and 0 in both standby conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write strobe clock; stores on rising edge |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane select (bits 15:8), active low |
| lb_n | input | 1 | Lower lane select (bits 7:0), active low |
| addr | input | ADDR_W | Word address: page field above a 4-bit word field |
| din | input | 16 | Write data (separate-signal variant) |
| dout | output | 16 | Stored word at `addr` |
| dout_en | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| power | output | 1 | 1 active, 0 standby |
| dq | inout | 16 | Shared bus, driven per lane in the tristate variant |

## Verification
The bench builds the block with ADDR_W=8 and USE_TRISTATE=0. This gives 16 pages of 16 words, small enough to write and read back every word-in-page position across several pages, including the highest address. With separate data signals, the bench sees per-lane drive directly on `dout_en` and does not need to resolve the bus. It pairs every mode with both lane-select patterns and both `oe_n` levels. Blocked writes and lane-masked writes are verified later by reading the words back.

// File: rtl/sram16_pkg.sv
package sram16_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 2;
   localparam int DATA_W = LANE_W * LANES;
   localparam int WORD_W = 4;

   typedef enum logic [1:0] {
      MODE_STBY  = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_READ  = 2'd2,
      MODE_WRITE = 2'd3
   } sram_mode_e;
endpackage

// File: rtl/sram16_ctrl.sv
module sram16_ctrl
   import sram16_pkg::*;
(
   input  logic             ce_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] sel_n,
   output sram_mode_e       mode,
   output logic [LANES-1:0] wr_lanes,
   output logic [LANES-1:0] rd_lanes,
   output logic             power
);
   logic any_lane;

   always_comb begin
      any_lane = |(~sel_n);
      if (ce_n || !any_lane)  mode = MODE_STBY;
      else if (!we_n)         mode = MODE_WRITE;
      else if (!oe_n)         mode = MODE_READ;
      else                    mode = MODE_IDLE;
   end

   assign wr_lanes = (mode == MODE_WRITE) ? ~sel_n : '0;
   assign rd_lanes = (mode == MODE_READ)  ? ~sel_n : '0;
   assign power    = (mode != MODE_STBY);
endmodule

// File: rtl/sram16_array.sv
module sram16_array
   import sram16_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                     clk,
   input  logic [ADDR_W-WORD_W-1:0] page,
   input  logic [WORD_W-1:0]        word,
   input  logic [LANES-1:0]         wr_lanes,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] idx;

   assign idx   = {page, word};
   assign rdata = mem[idx];

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wr_lanes[l]) mem[idx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/sram16_io.sv
module sram16_io
   import sram16_pkg::*;
#(
   parameter bit USE_TRISTATE = 1'b0
) (
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rdata,
   input  logic [LANES-1:0]  rd_lanes,
   output logic [DATA_W-1:0] wdata,
   inout  wire  [DATA_W-1:0] dq
);
   if (USE_TRISTATE) begin : g_bus
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign dq[g*LANE_W +: LANE_W] = rd_lanes[g] ? rdata[g*LANE_W +: LANE_W] : 'z;
      end
      assign wdata = dq;
   end else begin : g_split
      assign dq    = 'z;
      assign wdata = din;
   end
endmodule

// File: rtl/sram16_lane_model.sv
module sram16_lane_model
   import sram16_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter bit USE_TRISTATE = 1'b0
) (
   input  logic              clk,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  dout_en,
   output logic              power,
   inout  wire  [DATA_W-1:0] dq
);
   localparam int PAGE_W = ADDR_W - WORD_W;

   if (ADDR_W < WORD_W + 1) begin : g_bad_small
      $error("sram16_lane_model: ADDR_W must leave at least one page bit");
   end
   if (ADDR_W > 17) begin : g_bad_large
      $error("sram16_lane_model: ADDR_W above full organisation");
   end

   sram_mode_e        mode;
   logic [LANES-1:0]  wr_lanes;
   logic [LANES-1:0]  rd_lanes;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;

   sram16_ctrl u_ctrl (
      .ce_n     (ce_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .sel_n    ({ub_n, lb_n}),
      .mode     (mode),
      .wr_lanes (wr_lanes),
      .rd_lanes (rd_lanes),
      .power    (power)
   );

   sram16_array #(.ADDR_W(ADDR_W)) u_array (
      .clk      (clk),
      .page     (addr[ADDR_W-1:WORD_W]),
      .word     (addr[WORD_W-1:0]),
      .wr_lanes (wr_lanes),
      .wdata    (wdata),
      .rdata    (rdata)
   );

   sram16_io #(.USE_TRISTATE(USE_TRISTATE)) u_io (
      .din      (din),
      .rdata    (rdata),
      .rd_lanes (rd_lanes),
      .wdata    (wdata),
      .dq       (dq)
   );

   logic unused_mode;
   assign unused_mode = ^{mode, PAGE_W[0]};
   assign dout    = rdata;
   assign dout_en = rd_lanes;
endmodule

// File: rtl/sram16_lane_chk.sv
module sram16_lane_chk (
   input logic       clk,
   input logic       ce_n,
   input logic       we_n,
   input logic       oe_n,
   input logic       ub_n,
   input logic       lb_n,
   input logic [1:0] dout_en,
   input logic       power
);
   logic lane_any;
   assign lane_any = !(ub_n && lb_n);

   always_ff @(posedge clk) begin
      if (ce_n) begin
         AST_CE_STANDBY: assert (dout_en == 2'b00 && !power); // R2
      end
      if (!ce_n && ub_n && lb_n) begin
         AST_NOLANE_STANDBY: assert (dout_en == 2'b00 && !power); // R3
      end
      if (!ce_n && !we_n && lane_any) begin
         AST_WRITE_NO_DRIVE: assert (dout_en == 2'b00 && power); // R5
      end
      if (!ce_n && we_n && !oe_n && lane_any) begin
         AST_READ_LANES: assert (dout_en == {!ub_n, !lb_n} && power); // R7
      end
      if (!ce_n && we_n && oe_n && lane_any) begin
         AST_IDLE_ACTIVE: assert (dout_en == 2'b00 && power); // R8
      end
   end
endmodule

bind sram16_lane_model sram16_lane_chk u_chk (.*);

// File: tb/sram16_lane_model_tb.sv
module sram16_lane_model_tb;
   localparam int AW = 8;

   typedef struct {
      logic [1:0]  en;
      logic [15:0] data;
      logic        pwr;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic [1:0]    dout_en;
   logic          power;
   wire  [15:0]   dq_w;

   logic [15:0]   ref_mem [1<<AW];
   exp_t          q [$];
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   sram16_lane_model #(.ADDR_W(AW), .USE_TRISTATE(1'b0)) u_dut (
      .clk(clk), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .power(power), .dq(dq_w)
   );

   task automatic op(input logic c, input logic w, input logic o, input logic u,
                     input logic l, input logic [AW-1:0] a, input logic [15:0] d,
                     input string tag);
      exp_t e;
      logic act;
      @(negedge clk);
      ce_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; din = d;
      act   = !c && !(u && l);
      e.tag = tag;
      e.pwr = act;
      e.en  = 2'b00;
      e.data = 16'h0;
      if (act && !w) begin
         if (!l) ref_mem[a][7:0]  = d[7:0];
         if (!u) ref_mem[a][15:8] = d[15:8];
      end else if (act && !o) begin
         e.en   = {!u, !l};
         e.data = ref_mem[a] & {{8{!u}}, {8{!l}}};
      end
      q.push_back(e);
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0, tag);
   endtask

   initial begin : monitor
      exp_t e;
      logic [15:0] got;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() != 0) begin
            e   = q.pop_front();
            got = dout & {{8{dout_en[1]}}, {8{dout_en[0]}}};
            n_chk++;
            if (dout_en !== e.en || power !== e.pwr || got !== e.data) begin
               n_fail++;
               $display("FAIL %s: en=%b pwr=%b data=%h expected en=%b pwr=%b data=%h",
                        e.tag, dout_en, power, got, e.en, e.pwr, e.data);
            end
         end
      end
   end

   initial begin : watchdog
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : driver
      // Reset-state view: everything deasserted is standby (R2)
      op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0, "R2");
      // Full-word writes across pages and word fields, oe_n toggled (R1, R4, R5)
      for (int i = 0; i < 40; i++) begin
         logic [AW-1:0] a;
         a = AW'((i * 37 + 3) % 256);
         if (i == 39) a = 8'hFF;
         op(1'b0, 1'b0, logic'(i % 2), 1'b0, 1'b0, a, 16'(i * 16'h0913 + 16'h5A21),
            (i % 2) ? "R5" : "R4");
      end
      op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 16'h1111, "R1");
      op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h2222, "R1");
      for (int i = 0; i < 40; i++) begin
         logic [AW-1:0] a;
         a = AW'((i * 37 + 3) % 256);
         if (i == 39) a = 8'hFF;
         rd(a, "R6");
      end
      rd(8'h10, "R1");
      rd(8'h01, "R1");
      // Blocked writes in both standby conditions, then read back (R2, R3)
      op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 16'hDEAD, "R2");
      op(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 16'hBEEF, "R3");
      op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 16'h0, "R3");
      rd(8'h10, "R2");
      rd(8'h01, "R3");
      // Lane-masked writes (R7)
      op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 16'hA5C3, "R7");
      op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 16'h7E99, "R7");
      rd(8'h10, "R7");
      rd(8'h01, "R7");
      // Lane-masked reads (R7)
      op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 16'h0, "R7");
      op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 16'h0, "R7");
      op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 16'h0, "R7");
      // Idle: active but undriven, each lane pattern (R8, R9)
      op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 16'h0, "R8");
      op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 16'h0, "R8");
      op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 16'h0, "R9");
      // Standby with a read request pending (R2, R9)
      op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10, 16'h0, "R9");
      op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02, 16'h3C3C, "R9");
      rd(8'h02, "R9");
      op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0, "R2");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule